// File: doc/BRIEF.md
# Monochrome Hardware Cursor Overlay

This block places a 64x64 two-plane monochrome cursor over a 32-bit ARGB pixel stream during scan-out. The display timing logic gives it a fetch request during horizontal blanking, along with the number of the coming scan line. If that line crosses the cursor, the block reads the line's 16-byte cursor row from a pattern memory port. That port returns data one cycle after the request. As pixels of that line then stream through, each pixel inside the cursor window is resolved by an AND/XOR mask pair. The result is one of four things: the pixel passes unchanged, it is inverted, or it is replaced by one of two programmable 24-bit colours with opaque alpha.

Software programs the enable bit, the pattern base, the cursor position, the hotspot, the two colours and the display geometry through a plain register port. The position, the hotspot and the base feed a shadow copy. That copy is refreshed only on a frame-start pulse, and only while the lock bit is clear, so software can rewrite a cursor without tearing. The pixel path is valid/ready and adds one register stage. An input pixel is accepted when `in_ready` is high. `in_ready` is high whenever the output register is empty or the consumer takes its content in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds and back-pressure stalls the input.

Top module: `cursor_overlay`

## Requirements
- R1: The pixel stream has a latency of one register. `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid=1` and `out_ready=0`, `out_valid` and `out_pix` stay unchanged. After reset, `out_valid` is 0.
- R2: While the enable bit (register 0, bit 0) is clear, every pixel leaves unchanged and no pattern read is issued.
- R3: A cursor row is 16 bytes. Byte k sits at `pat_rd_data[8k+7:8k]`. Bytes 0–7 form the AND plane and bytes 8–15 form the XOR plane. Cursor column c uses bit 7-(c mod 8) of byte c/8 of each plane, so the MSB of a byte is the leftmost pixel.
- R4: AND=1 with XOR=0 leaves the pixel unchanged. AND=1 with XOR=1 outputs the bitwise complement of all 32 bits of the pixel.
- R5: AND=0 outputs colour 1 (register 5) when XOR=1 and colour 0 (register 4) when XOR=0. Bits [23:0] come from the colour register and bits [31:24] are forced to 0xFF.
- R6: A pixel is drawn only when its column x lies in [X, X+63] and x < (H+1)*8. H is register 6, bits [10:0]. Columns at or past that width pass unchanged, so the cursor never wraps.
- R7: A line y fetches and draws only when y lies in [Y, Y+63] and y ≤ V. V is register 7, bits [11:0]. Other lines pass unchanged, and no pattern read is issued for them.
- R8: One cycle after a fetch request inside the window, `pat_rd_en` pulses with address base − hx − 16·hy + 16·(y−Y). The row becomes usable two cycles after that pulse.
- R9: The lock is bit 31 of the base register (register 1, address in bits [26:4]). A write to position (register 2: X in [29:16], Y in [11:0]) or to hotspot (register 3: hx in [21:16], hy in [5:0]) loads bit 31 of the written data into the lock. A read of registers 1, 2 and 3 returns the lock in bit 31.
- R10: On `frame_start` with the lock clear, the drawn position, hotspot and base take the register values. While the lock is set, they keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| frame_start | input | 1 | Frame-start pulse; refreshes the shadow copy when unlocked |
| fetch_req | input | 1 | Blanking-time request to prefetch the row for `fetch_y` |
| fetch_y | input | 12 | Scan line for the coming row |
| pat_rd_en | output | 1 | Pattern memory read strobe |
| pat_rd_addr | output | 27 | Byte address of the 16-byte row |
| pat_rd_data | input | 128 | Row data, valid one cycle after `pat_rd_en` |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with `in_valid` |
| in_pix | input | 32 | Input ARGB pixel |
| in_x | input | 14 | Column of the input pixel |
| in_y | input | 12 | Scan line of the input pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_pix | output | 32 | Output ARGB pixel |

## Verification
The assertions assume that `fetch_req` is a single-cycle pulse. They also assume consecutive pulses are at least three cycles apart, so that a row read never overlaps the next request. The assertions further assume that the pixels of a line arrive only after that line's row has landed. The stimulus follows each fetch with several idle cycles before it sends that line's pixels. It changes registers only between lines, and it issues `frame_start` only while the pixel path is idle.

// File: rtl/curs_pkg.sv
package curs_pkg;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_BASE  = 3'd1,
    REG_POS   = 3'd2,
    REG_HOT   = 3'd3,
    REG_COL0  = 3'd4,
    REG_COL1  = 3'd5,
    REG_HDISP = 3'd6,
    REG_VDISP = 3'd7
  } cfg_reg_e;

  typedef enum logic [1:0] {
    PX_PASS   = 2'd0,
    PX_INVERT = 2'd1,
    PX_COL0   = 2'd2,
    PX_COL1   = 2'd3
  } px_act_e;

  localparam int unsigned LOCK_BIT  = 31;
  localparam int unsigned POS_X_LSB = 16;
  localparam int unsigned HOT_X_LSB = 16;
  localparam int unsigned BASE_LSB  = 4;

endpackage

// File: rtl/curs_regs.sv
module curs_regs
  import curs_pkg::*;
#(
  parameter int unsigned X_W    = 14,
  parameter int unsigned Y_W    = 12,
  parameter int unsigned ADDR_W = 27,
  parameter int unsigned HS_W   = 6,
  parameter int unsigned HF_W   = 11,
  parameter int unsigned COL_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              frame_start,
  output logic              cur_en,
  output logic [COL_W-1:0]  col0,
  output logic [COL_W-1:0]  col1,
  output logic [X_W:0]      act_width,
  output logic [Y_W-1:0]    vlimit,
  output logic [X_W-1:0]    sh_x,
  output logic [Y_W-1:0]    sh_y,
  output logic [ADDR_W-1:0] sh_base
);

  logic                     en_q, lock_q;
  logic [ADDR_W-1:BASE_LSB] base_q;
  logic [X_W-1:0]           px_q;
  logic [Y_W-1:0]           py_q;
  logic [HS_W-1:0]          hx_q, hy_q;
  logic [COL_W-1:0]         c0_q, c1_q;
  logic [HF_W-1:0]          hf_q;
  logic [Y_W-1:0]           vf_q;
  logic                     unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      base_q <= '0;
      px_q   <= '0;
      py_q   <= '0;
      hx_q   <= '0;
      hy_q   <= '0;
      c0_q   <= '0;
      c1_q   <= '0;
      hf_q   <= '0;
      vf_q   <= '0;
    end else if (cfg_we) begin
      unique case (cfg_reg_e'(cfg_addr))
        REG_CTRL:  en_q <= cfg_wdata[0];
        REG_BASE: begin
          base_q <= cfg_wdata[ADDR_W-1:BASE_LSB];
          lock_q <= cfg_wdata[LOCK_BIT];
        end
        REG_POS: begin
          px_q   <= cfg_wdata[POS_X_LSB +: X_W];
          py_q   <= cfg_wdata[Y_W-1:0];
          lock_q <= cfg_wdata[LOCK_BIT];
        end
        REG_HOT: begin
          hx_q   <= cfg_wdata[HOT_X_LSB +: HS_W];
          hy_q   <= cfg_wdata[HS_W-1:0];
          lock_q <= cfg_wdata[LOCK_BIT];
        end
        REG_COL0:  c0_q <= cfg_wdata[COL_W-1:0];
        REG_COL1:  c1_q <= cfg_wdata[COL_W-1:0];
        REG_HDISP: hf_q <= cfg_wdata[HF_W-1:0];
        REG_VDISP: vf_q <= cfg_wdata[Y_W-1:0];
        default: ;
      endcase
    end
  end

  // Shadow copy used by the drawing path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_x    <= '0;
      sh_y    <= '0;
      sh_base <= '0;
    end else if (frame_start && !lock_q) begin
      sh_x    <= px_q;
      sh_y    <= py_q;
      sh_base <= {base_q, {BASE_LSB{1'b0}}} - ADDR_W'(hx_q)
                 - (ADDR_W'(hy_q) << 4);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_reg_e'(cfg_addr))
      REG_CTRL: cfg_rdata[0] = en_q;
      REG_BASE: begin
        cfg_rdata[ADDR_W-1:BASE_LSB] = base_q;
        cfg_rdata[LOCK_BIT]          = lock_q;
      end
      REG_POS: begin
        cfg_rdata[POS_X_LSB +: X_W] = px_q;
        cfg_rdata[Y_W-1:0]          = py_q;
        cfg_rdata[LOCK_BIT]         = lock_q;
      end
      REG_HOT: begin
        cfg_rdata[HOT_X_LSB +: HS_W] = hx_q;
        cfg_rdata[HS_W-1:0]          = hy_q;
        cfg_rdata[LOCK_BIT]          = lock_q;
      end
      REG_COL0:  cfg_rdata[COL_W-1:0] = c0_q;
      REG_COL1:  cfg_rdata[COL_W-1:0] = c1_q;
      REG_HDISP: cfg_rdata[HF_W-1:0]  = hf_q;
      REG_VDISP: cfg_rdata[Y_W-1:0]   = vf_q;
      default: ;
    endcase
  end

  assign cur_en    = en_q;
  assign col0      = c0_q;
  assign col1      = c1_q;
  assign vlimit    = vf_q;
  assign act_width = (X_W+1)'({({1'b0, hf_q} + (HF_W+1)'(1)), 3'b000});

  // R10: a locked frame start keeps the drawn geometry
  a_r10_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && lock_q) |=> ($stable(sh_x) && $stable(sh_y) && $stable(sh_base)));

  // R10: geometry moves only on a frame start
  a_r10_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(sh_x) && $stable(sh_y) && $stable(sh_base)));

  // R9: a position write loads the lock from bit 31
  a_r9_pos_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == REG_POS) |=> (lock_q == $past(cfg_wdata[LOCK_BIT])));

endmodule

// File: rtl/curs_fetch.sv
module curs_fetch #(
  parameter int unsigned Y_W     = 12,
  parameter int unsigned ADDR_W  = 27,
  parameter int unsigned CUR_DIM = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_req,
  input  logic [Y_W-1:0]         fetch_y,
  input  logic                   cur_en,
  input  logic [Y_W-1:0]         vlimit,
  input  logic [Y_W-1:0]         sh_y,
  input  logic [ADDR_W-1:0]      sh_base,
  output logic                   pat_rd_en,
  output logic [ADDR_W-1:0]      pat_rd_addr,
  input  logic [2*CUR_DIM-1:0]   pat_rd_data,
  output logic                   row_hit,
  output logic [Y_W-1:0]         row_y,
  output logic [2*CUR_DIM-1:0]   row_bits
);

  localparam int unsigned IW        = $clog2(CUR_DIM);
  localparam int unsigned ROW_BYTES = (2 * CUR_DIM) / 8;
  localparam int unsigned RB_SH     = $clog2(ROW_BYTES);

  logic [Y_W:0] dy;
  logic         in_win;
  logic         pend_q;

  assign dy     = {1'b0, fetch_y} - {1'b0, sh_y};
  assign in_win = cur_en && !dy[Y_W] && (dy < (Y_W+1)'(CUR_DIM)) &&
                  (fetch_y <= vlimit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_rd_en   <= 1'b0;
      pat_rd_addr <= '0;
      pend_q      <= 1'b0;
      row_hit     <= 1'b0;
      row_y       <= '0;
      row_bits    <= '0;
    end else begin
      pat_rd_en <= fetch_req && in_win;
      if (fetch_req && in_win)
        pat_rd_addr <= sh_base + (ADDR_W'(dy[IW-1:0]) << RB_SH);
      pend_q <= pat_rd_en;
      if (fetch_req) begin
        row_hit <= 1'b0;
        row_y   <= fetch_y;
      end else if (pend_q) begin
        row_hit  <= 1'b1;
        row_bits <= pat_rd_data;
      end
    end
  end

  // R8: read strobe is a single pulse per fetch
  a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rd_en |=> !pat_rd_en);

  // R8: returned row becomes usable two cycles after the strobe
  a_r8_row_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pat_rd_en) && !fetch_req) |=> row_hit);

  // R7: a new request invalidates the held row
  a_r7_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !row_hit);

endmodule

// File: rtl/curs_mix.sv
module curs_mix
  import curs_pkg::*;
#(
  parameter int unsigned X_W     = 14,
  parameter int unsigned Y_W     = 12,
  parameter int unsigned PIX_W   = 32,
  parameter int unsigned COL_W   = 24,
  parameter int unsigned CUR_DIM = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PIX_W-1:0]     in_pix,
  input  logic [X_W-1:0]       in_x,
  input  logic [Y_W-1:0]       in_y,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PIX_W-1:0]     out_pix,
  input  logic                 cur_en,
  input  logic [COL_W-1:0]     col0,
  input  logic [COL_W-1:0]     col1,
  input  logic [X_W:0]         act_width,
  input  logic [X_W-1:0]       sh_x,
  input  logic                 row_hit,
  input  logic [Y_W-1:0]       row_y,
  input  logic [2*CUR_DIM-1:0] row_bits
);

  localparam int unsigned IW      = $clog2(CUR_DIM);
  localparam int unsigned ALPHA_W = PIX_W - COL_W;

  logic [X_W:0]       dx;
  logic [IW-1:0]      col;
  logic [IW-1:0]      bit_idx;
  logic               in_h, hit, and_b, xor_b, take;
  px_act_e            act;
  logic [PIX_W-1:0]   mixed;

  assign dx      = {1'b0, in_x} - {1'b0, sh_x};
  assign col     = dx[IW-1:0];
  // byte = col/8, bit = 7 - col%8
  assign bit_idx = {col[IW-1:3], ~col[2:0]};
  assign in_h    = !dx[X_W] && (dx < (X_W+1)'(CUR_DIM)) &&
                   ({1'b0, in_x} < act_width);
  assign hit     = cur_en && row_hit && (row_y == in_y) && in_h;
  assign and_b   = row_bits[bit_idx];
  assign xor_b   = row_bits[CUR_DIM + bit_idx];

  always_comb begin
    if (!hit)       act = PX_PASS;
    else if (and_b) act = xor_b ? PX_INVERT : PX_PASS;
    else            act = xor_b ? PX_COL1 : PX_COL0;
  end

  always_comb begin
    unique case (act)
      PX_PASS:   mixed = in_pix;
      PX_INVERT: mixed = ~in_pix;
      PX_COL0:   mixed = {{ALPHA_W{1'b1}}, col0};
      PX_COL1:   mixed = {{ALPHA_W{1'b1}}, col1};
      default:   mixed = in_pix;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_pix   <= mixed;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1: stalled output holds
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  // R2: disabled cursor passes the accepted pixel
  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cur_en) |=> (out_pix == $past(in_pix)));

  // R5: colour outputs are opaque
  a_r5_alpha: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit && !and_b) |=> (out_pix[PIX_W-1:COL_W] == {ALPHA_W{1'b1}}));

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int unsigned X_W     = 14,
  parameter int unsigned Y_W     = 12,
  parameter int unsigned ADDR_W  = 27,
  parameter int unsigned CUR_DIM = 64,
  parameter int unsigned HF_W    = 11,
  parameter int unsigned PIX_W   = 32,
  parameter int unsigned COL_W   = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [2:0]             cfg_addr,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic                   frame_start,
  input  logic                   fetch_req,
  input  logic [Y_W-1:0]         fetch_y,
  output logic                   pat_rd_en,
  output logic [ADDR_W-1:0]      pat_rd_addr,
  input  logic [2*CUR_DIM-1:0]   pat_rd_data,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PIX_W-1:0]       in_pix,
  input  logic [X_W-1:0]         in_x,
  input  logic [Y_W-1:0]         in_y,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PIX_W-1:0]       out_pix
);

  localparam int unsigned HS_W = $clog2(CUR_DIM);

  logic                   cur_en;
  logic [COL_W-1:0]       col0, col1;
  logic [X_W:0]           act_width;
  logic [Y_W-1:0]         vlimit;
  logic [X_W-1:0]         sh_x;
  logic [Y_W-1:0]         sh_y;
  logic [ADDR_W-1:0]      sh_base;
  logic                   row_hit;
  logic [Y_W-1:0]         row_y;
  logic [2*CUR_DIM-1:0]   row_bits;

  curs_regs #(
    .X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W), .HS_W(HS_W),
    .HF_W(HF_W), .COL_W(COL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .frame_start(frame_start),
    .cur_en(cur_en), .col0(col0), .col1(col1),
    .act_width(act_width), .vlimit(vlimit),
    .sh_x(sh_x), .sh_y(sh_y), .sh_base(sh_base)
  );

  curs_fetch #(
    .Y_W(Y_W), .ADDR_W(ADDR_W), .CUR_DIM(CUR_DIM)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_y(fetch_y),
    .cur_en(cur_en), .vlimit(vlimit), .sh_y(sh_y), .sh_base(sh_base),
    .pat_rd_en(pat_rd_en), .pat_rd_addr(pat_rd_addr),
    .pat_rd_data(pat_rd_data),
    .row_hit(row_hit), .row_y(row_y), .row_bits(row_bits)
  );

  curs_mix #(
    .X_W(X_W), .Y_W(Y_W), .PIX_W(PIX_W), .COL_W(COL_W), .CUR_DIM(CUR_DIM)
  ) u_mix (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .cur_en(cur_en), .col0(col0), .col1(col1), .act_width(act_width),
    .sh_x(sh_x), .row_hit(row_hit), .row_y(row_y), .row_bits(row_bits)
  );

endmodule

// File: tb/test_cursor_overlay.sv
`timescale 1ns/1ps
module test_cursor_overlay;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic         frame_start = 1'b0;
  logic         fetch_req = 1'b0;
  logic [11:0]  fetch_y = '0;
  logic         pat_rd_en;
  logic [26:0]  pat_rd_addr;
  logic [127:0] pat_rd_data = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_pix = '0;
  logic [13:0]  in_x = '0;
  logic [11:0]  in_y = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [31:0]  out_pix;

  always #10 clk = ~clk;

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_start(frame_start),
    .fetch_req(fetch_req), .fetch_y(fetch_y), .pat_rd_en(pat_rd_en),
    .pat_rd_addr(pat_rd_addr), .pat_rd_data(pat_rd_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  logic [7:0] mem [4096];

  always @(posedge clk)
    if (pat_rd_en)
      for (int k = 0; k < 16; k++)
        pat_rd_data[8*k +: 8] <= mem[12'(pat_rd_addr[11:0] + 12'(k))];

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  bit m_en, m_lock;
  int m_base, m_px, m_py, m_hx, m_hy, m_c0, m_c1, m_hf, m_vf;
  int s_px, s_py, s_base;
  bit row_ok; int row_y, row_base;
  bit seen_en; int seen_addr;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      0: m_en = d[0];
      1: begin m_base = int'(d[26:4]) * 16; m_lock = d[31]; end
      2: begin m_px = int'(d[29:16]); m_py = int'(d[11:0]); m_lock = d[31]; end
      3: begin m_hx = int'(d[21:16]); m_hy = int'(d[5:0]); m_lock = d[31]; end
      4: m_c0 = int'(d[23:0]);
      5: m_c1 = int'(d[23:0]);
      6: m_hf = int'(d[10:0]);
      default: m_vf = int'(d[11:0]);
    endcase
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 3'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    if (!m_lock) begin
      s_px = m_px; s_py = m_py; s_base = m_base - m_hx - 16 * m_hy;
    end
  endtask

  task automatic fetch(input int y);
    @(negedge clk); fetch_req = 1'b1; fetch_y = 12'(y);
    row_ok = m_en && y >= s_py && y < s_py + 64 && y <= m_vf;
    row_y = y; row_base = s_base + 16 * (y - s_py);
    @(negedge clk); fetch_req = 1'b0;
    seen_en = pat_rd_en; seen_addr = int'(pat_rd_addr);
    repeat (4) @(negedge clk);
  endtask

  // expected pixel from requirements R2..R7; cls: 0 pass-outside,1 and-plane,2 colour
  function automatic logic [31:0] exp_pix(input int x, input int y, input logic [31:0] p, output int cls);
    int dx; bit a, xb;
    cls = 0;
    if (!(m_en && row_ok && y == row_y)) return p;
    dx = x - s_px;
    if (dx < 0 || dx > 63 || x >= (m_hf + 1) * 8) return p;
    a  = mem[12'(row_base + dx / 8)][7 - dx % 8];
    xb = mem[12'(row_base + 8 + dx / 8)][7 - dx % 8];
    if (a) begin cls = 1; return xb ? ~p : p; end
    cls = 2;
    return {8'hFF, xb ? m_c1[23:0] : m_c0[23:0]};
  endfunction

  task automatic pix(input int x, input int y, input logic [31:0] p, input string tag);
    logic [31:0] e; int cls;
    e = exp_pix(x, y, p, cls);
    @(negedge clk);
    in_valid = 1'b1; in_x = 14'(x); in_y = 12'(y); in_pix = p;
    @(negedge clk);
    in_valid = 1'b0;
    if (tag != "") check(out_valid && out_pix === e, tag, out_pix, e);
    else if (cls == 0) check(out_valid && out_pix === e, "R6/R7 window", out_pix, e);
    else if (cls == 1) check(out_valid && out_pix === e, "R4 and-plane", out_pix, e);
    else check(out_valid && out_pix === e, "R5 colour", out_pix, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    m_en = 0; m_lock = 0; m_base = 0; m_px = 0; m_py = 0; m_hx = 0; m_hy = 0;
    m_c0 = 0; m_c1 = 0; m_hf = 0; m_vf = 0; s_px = 0; s_py = 0; s_base = 0;
    row_ok = 0; row_y = 0; row_base = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 reset out_valid", {31'b0, out_valid}, 32'h0);
    check(in_ready === 1'b1, "R1 reset in_ready", {31'b0, in_ready}, 32'h1);
    rd(2, r); check(r === 32'h0, "R9 reset pos", r, 32'h0);

    // R9 lock through position / hotspot
    wr(2, 32'h8000_0000 | (32'd300 << 16) | 32'd20);
    rd(2, r); check(r === (32'h8000_0000 | (32'd300 << 16) | 32'd20), "R9 pos read with lock", r, 32'h812c0014);
    rd(1, r); check(r[31] === 1'b1, "R9 base lock bit", r, 32'h8000_0000);
    wr(3, (32'd2 << 16) | 32'd1);
    rd(2, r); check(r[31] === 1'b0, "R9 hotspot clears lock", r, 32'h012c0014);
    rd(3, r); check(r === ((32'd2 << 16) | 32'd1), "R9 hotspot read", r, 32'h00020001);

    // directed setup: base 0x100, hotspot (2,1), pos (100,10)
    wr(1, 32'h100); wr(2, (32'd100 << 16) | 32'd10); wr(3, (32'd2 << 16) | 32'd1);
    wr(4, 32'h12_3456); wr(5, 32'hAB_CDEF); wr(6, 63); wr(7, 400);
    for (int k = 0; k < 16; k++) mem[12'h11E + k] = 8'h00;
    mem[12'h11E] = 8'h80; mem[12'h11E + 8] = 8'h40;
    mem[12'h11E + 7] = 8'h01; mem[12'h11E + 15] = 8'h01;
    frame();

    // R2 disabled
    fetch(13);
    check(seen_en === 1'b0, "R2 no read while disabled", {31'b0, seen_en}, 32'h0);
    pix(101, 13, 32'h1111_2222, "R2 disabled passes");

    wr(0, 1);
    fetch(13);
    check(seen_en === 1'b1 && seen_addr == 32'h11E, "R8 read address", 32'(seen_addr), 32'h11E);
    pix(100, 13, 32'h0102_0304, "R4 transparent col0");
    check(out_pix === 32'h0102_0304, "R3 msb leftmost", out_pix, 32'h0102_0304);
    pix(101, 13, 32'h0102_0304, "R5 colour1 col1");
    check(out_pix === 32'hFFAB_CDEF, "R3 xor plane byte8", out_pix, 32'hFFABCDEF);
    pix(102, 13, 32'h0102_0304, "R5 colour0 col2");
    check(out_pix === 32'hFF12_3456, "R5 colour0 value", out_pix, 32'hFF123456);
    pix(163, 13, 32'h0F0F_00FF, "R4 invert col63");
    check(out_pix === 32'hF0F0_FF00, "R4 invert value", out_pix, 32'hF0F0FF00);
    pix(164, 13, 32'h5555_5555, "R6 right of window");
    pix(99, 13, 32'h5555_5555, "R6 left of window");
    pix(100, 14, 32'h5555_5555, "R7 row mismatch");

    // R6 clip at width 112
    wr(6, 13);
    pix(111, 13, 32'h7777_7777, "R6 last column before clip");
    pix(112, 13, 32'h7777_7777, "R6 clipped column");
    check(out_pix === 32'h7777_7777, "R6 no wrap", out_pix, 32'h77777777);
    wr(6, 63);

    // R7 vertical window
    fetch(74);
    check(seen_en === 1'b0, "R7 no read below window", {31'b0, seen_en}, 32'h0);
    pix(101, 74, 32'h2468_ACE0, "R7 below window");
    fetch(73);
    check(seen_en === 1'b1, "R7 last row reads", {31'b0, seen_en}, 32'h1);
    pix(101, 73, 32'h2468_ACE0, "R7 last row");
    fetch(9);
    pix(101, 9, 32'h2468_ACE0, "R7 above window");
    wr(7, 12);
    fetch(13);
    check(seen_en === 1'b0, "R7 vertical limit blocks read", {31'b0, seen_en}, 32'h0);
    pix(101, 13, 32'h2468_ACE0, "R7 beyond vertical limit");
    wr(7, 400);

    // R1 back-pressure
    fetch(13);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_x = 14'd101; in_y = 12'd13; in_pix = 32'h0;
    @(negedge clk);
    check(out_valid === 1'b1 && in_ready === 1'b0, "R1 stall blocks input", {31'b0, in_ready}, 32'h0);
    in_x = 14'd102;
    repeat (2) @(negedge clk);
    check(out_pix === 32'hFFAB_CDEF, "R1 output held", out_pix, 32'hFFABCDEF);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_pix === 32'hFF12_3456, "R1 next after release", out_pix, 32'hFF123456);

    // R10 lock holds shadow
    wr(2, 32'h8000_0000 | (32'd300 << 16) | 32'd10);
    frame();
    fetch(13);
    pix(101, 13, 32'h0, "R10 locked keeps old position");
    check(out_pix === 32'hFFAB_CDEF, "R10 old position drawn", out_pix, 32'hFFABCDEF);
    wr(3, (32'd2 << 16) | 32'd1);
    frame();
    fetch(13);
    pix(101, 13, 32'h3333_3333, "R10 unlocked moves away");
    pix(301, 13, 32'h0, "R10 new position drawn");

    // random frames
    for (int f = 0; f < 8; f++) begin
      wr(1, 32'(2048 + ($urandom % 64) * 16));
      wr(2, (32'(8 + $urandom % 200) << 16) | 32'($urandom % 100));
      wr(3, (32'($urandom % 64) << 16) | 32'($urandom % 64));
      wr(4, $urandom); wr(5, $urandom);
      wr(6, 8 + $urandom % 40);
      wr(7, m_py + 20 + $urandom % 60);
      frame();
      for (int l = 0; l < 6; l++) begin
        int y;
        y = m_py - 2 + int'($urandom % 70);
        if (y < 0) y = 0;
        fetch(y);
        for (int p = 0; p < 24; p++)
          pix(s_px - 8 + int'($urandom % 80), y, $urandom, "");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule